// File: doc/BRIEF.md
# Composite-Field AES Substitution Box

This block replaces one byte with its AES substitution, in either direction, without a 256-entry table. The byte is carried by a fixed linear change of basis into GF((2^4)^2). There it is inverted through a 4-bit norm and a conjugate, and then carried back. The affine step of the cipher is folded into the linear maps on either side of that inverter. A single mode bit selects where it is applied: after the inversion for encryption, and before it for decryption. The hardware that inverts is therefore present only once and serves both directions. Only one direction is used in any given cycle.

A parent datapath presents one byte and the mode bit per cycle. With the default parameter setting, the result appears on the output register one clock later. If the register is disabled, the block is purely combinational from input to output. An asynchronous active-low reset clears the output register.

Top module: `sbox_cf`

## Requirements
- R1: With `inv_mode_i` = 0, `data_o` equals the standard AES forward S-box value of `data_i`, for all 256 input bytes (for example 0x01 gives 0x7C and 0x53 gives 0xED).
- R2: With `inv_mode_i` = 1, `data_o` equals the standard AES inverse S-box value of `data_i`, for all 256 input bytes (for example 0x00 gives 0x52).
- R3: Zero has no multiplicative inverse and is treated as its own inverse: forward 0x00 gives 0x63, inverse 0x63 gives 0x00, and the shared inverter returns zero exactly when its input is zero.
- R4: Feeding a forward result back in with `inv_mode_i` = 1 returns the original byte.
- R5: With `OUT_REG` = 1, `data_o` changes only at a rising edge of `clk_i`. It shows the function of the `data_i` and `inv_mode_i` sampled at that edge, so a new input is visible exactly one cycle after it is applied.
- R6: While `rst_ni` is low, `data_o` reads 0x00 whatever the inputs are, including an input whose substitution is nonzero.
- R7: The block holds no state between bytes. Inputs that change every cycle, with the mode alternating freely, each produce their correct result in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| data_i | input | 8 | Byte to substitute |
| inv_mode_i | input | 1 | 0 selects the forward S-box, 1 selects the inverse S-box |
| data_o | output | 8 | Substituted byte |

## Verification
With the default output register, every substituted byte is due on `data_o` one rising edge after the input is applied. The bench changes inputs on falling edges and reads the result at the next falling edge, half a period after the loading edge. For R5 it also reads the output one time unit after an input change, before any edge, and expects the previous result still to be there. For the back-to-back stream of R7, each cycle's expected value is held one cycle and compared while the next byte is being driven. During reset the output is read asynchronously, with no edge involved.

// File: rtl/sbox_cf_pkg.sv
package sbox_cf_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int MAT_W  = BYTE_W * BYTE_W;
    localparam int NUM_BYTES = 1 << BYTE_W;
    localparam int NUM_NIBS  = 1 << NIB_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [MAT_W-1:0]  mat_t;   // column k lives at [k*BYTE_W +: BYTE_W]

    typedef struct packed {
        byte_t data;
    } out_state_t;

    // GF(2^4) with y^4 = y + 1
    function automatic nib_t nib_mul(nib_t a, nib_t b);
        nib_t acc = '0;
        nib_t sh  = a;
        for (int i = 0; i < NIB_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[NIB_W-2:0], 1'b0} ^ (sh[NIB_W-1] ? 4'h3 : 4'h0);
        end
        return acc;
    endfunction

    function automatic nib_t nib_sq(nib_t a);
        return nib_mul(a, a);
    endfunction

    // GF(2^8) with x^8 = x^4 + x^3 + x + 1
    function automatic byte_t byte_mul(byte_t a, byte_t b);
        byte_t acc = '0;
        byte_t sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[BYTE_W-2:0], 1'b0} ^ (sh[BYTE_W-1] ? 8'h1B : 8'h00);
        end
        return acc;
    endfunction

    function automatic byte_t mat_apply(mat_t m, byte_t v);
        byte_t r = '0;
        for (int k = 0; k < BYTE_W; k++)
            if (v[k]) r = r ^ m[k*BYTE_W +: BYTE_W];
        return r;
    endfunction

    function automatic byte_t rotl(byte_t v, int n);
        byte_t r = v;
        for (int i = 0; i < n; i++) r = {r[BYTE_W-2:0], r[BYTE_W-1]};
        return r;
    endfunction

    // linear parts of the cipher's affine step and of its inverse
    function automatic byte_t aff_lin(byte_t v);
        return v ^ rotl(v, 1) ^ rotl(v, 2) ^ rotl(v, 3) ^ rotl(v, 4);
    endfunction

    function automatic byte_t inv_aff_lin(byte_t v);
        return rotl(v, 1) ^ rotl(v, 3) ^ rotl(v, 6);
    endfunction

    // constant for x^2 + x + lambda, irreducible over GF(2^4)
    function automatic nib_t pick_lambda();
        nib_t sel   = '0;
        bit   found = 1'b0;
        for (int l = 1; l < NUM_NIBS; l++) begin
            bit has_root = 1'b0;
            for (int t = 0; t < NUM_NIBS; t++)
                if ((nib_sq(nib_t'(t)) ^ nib_t'(t)) == nib_t'(l)) has_root = 1'b1;
            if (!has_root && !found) begin
                sel   = nib_t'(l);
                found = 1'b1;
            end
        end
        return sel;
    endfunction

    // image of y: a root of y^4 + y + 1 inside GF(2^8)
    function automatic byte_t pick_y();
        byte_t sel   = '0;
        bit    found = 1'b0;
        for (int v = 2; v < NUM_BYTES; v++) begin
            byte_t b  = byte_t'(v);
            byte_t b2 = byte_mul(b, b);
            if (!found && ((byte_mul(b2, b2) ^ b ^ 8'h01) == 8'h00)) begin
                sel   = b;
                found = 1'b1;
            end
        end
        return sel;
    endfunction

    function automatic byte_t pick_x(byte_t lam_img);
        byte_t sel   = '0;
        bit    found = 1'b0;
        for (int v = 2; v < NUM_BYTES; v++) begin
            byte_t b = byte_t'(v);
            if (!found && ((byte_mul(b, b) ^ b ^ lam_img) == 8'h00)) begin
                sel   = b;
                found = 1'b1;
            end
        end
        return sel;
    endfunction

    // composite {a,b} (P = a*x + b) -> standard byte
    function automatic mat_t build_phi();
        mat_t  m    = '0;
        byte_t y    = pick_y();
        nib_t  lam  = pick_lambda();
        byte_t ypow = 8'h01;
        byte_t limg = '0;
        byte_t x;
        for (int i = 0; i < NIB_W; i++) begin
            if (lam[i]) limg = limg ^ ypow;
            ypow = byte_mul(ypow, y);
        end
        x    = pick_x(limg);
        ypow = 8'h01;
        for (int k = 0; k < NIB_W; k++) begin
            m[k*BYTE_W +: BYTE_W]         = ypow;
            m[(k+NIB_W)*BYTE_W +: BYTE_W] = byte_mul(x, ypow);
            ypow = byte_mul(ypow, y);
        end
        return m;
    endfunction

    function automatic mat_t build_psi(mat_t phi);
        mat_t m = '0;
        for (int c = 0; c < NUM_BYTES; c++) begin
            byte_t v = mat_apply(phi, byte_t'(c));
            for (int j = 0; j < BYTE_W; j++)
                if (v == (byte_t'(1) << j)) m[j*BYTE_W +: BYTE_W] = byte_t'(c);
        end
        return m;
    endfunction

    function automatic mat_t build_fwd_out(mat_t phi);
        mat_t m = '0;
        for (int k = 0; k < BYTE_W; k++)
            m[k*BYTE_W +: BYTE_W] = aff_lin(phi[k*BYTE_W +: BYTE_W]);
        return m;
    endfunction

    function automatic mat_t build_inv_in(mat_t psi);
        mat_t m = '0;
        for (int k = 0; k < BYTE_W; k++)
            m[k*BYTE_W +: BYTE_W] = mat_apply(psi, inv_aff_lin(byte_t'(1) << k));
        return m;
    endfunction

    localparam nib_t  LAMBDA      = pick_lambda();
    localparam mat_t  PHI_MAT     = build_phi();
    localparam mat_t  PSI_MAT     = build_psi(PHI_MAT);
    localparam byte_t FWD_CONST   = 8'h63;
    localparam byte_t INV_CONST   = 8'h05;
    localparam mat_t  FWD_IN_MAT  = PSI_MAT;
    localparam mat_t  INV_IN_MAT  = build_inv_in(PSI_MAT);
    localparam byte_t INV_IN_OFS  = mat_apply(PSI_MAT, INV_CONST);
    localparam mat_t  FWD_OUT_MAT = build_fwd_out(PHI_MAT);
    localparam mat_t  INV_OUT_MAT = PHI_MAT;

endpackage

// File: rtl/sbox_cf_linmap.sv
module sbox_cf_linmap
    import sbox_cf_pkg::*;
#(
    parameter mat_t  MAT = '0,
    parameter byte_t OFS = '0
) (
    input  byte_t vec_i,
    output byte_t vec_o
);

    // fixed GF(2) matrix: each output bit is an XOR tree of input bits
    always_comb begin
        vec_o = mat_apply(MAT, vec_i) ^ OFS;
    end

endmodule

// File: rtl/sbox_cf_nib_inv.sv
module sbox_cf_nib_inv
    import sbox_cf_pkg::*;
(
    input  nib_t nib_i,
    output nib_t nib_o
);

    nib_t p2, p4, p8;

    // a^-1 = a^14 = a^8 * a^4 * a^2 ; zero yields zero
    always_comb begin
        p2    = nib_sq(nib_i);
        p4    = nib_sq(p2);
        p8    = nib_sq(p4);
        nib_o = nib_mul(nib_mul(p8, p4), p2);
    end

endmodule

// File: rtl/sbox_cf_inverter.sv
module sbox_cf_inverter
    import sbox_cf_pkg::*;
(
    input  byte_t cf_i,
    output byte_t cf_o
);

    nib_t hi, lo, norm, norm_inv;

    always_comb begin
        hi   = cf_i[BYTE_W-1:NIB_W];
        lo   = cf_i[NIB_W-1:0];
        // P^17 = hi^2*lambda + hi*lo + lo^2, a subfield element
        norm = nib_mul(nib_sq(hi), LAMBDA) ^ nib_mul(hi, lo) ^ nib_sq(lo);
    end

    sbox_cf_nib_inv u_nib_inv (
        .nib_i (norm),
        .nib_o (norm_inv)
    );

    // P^-1 = (P^17)^-1 * P^16, with P^16 = hi*x + (hi ^ lo)
    always_comb begin
        cf_o = {nib_mul(norm_inv, hi), nib_mul(norm_inv, hi ^ lo)};
    end

endmodule

// File: rtl/sbox_cf.sv
module sbox_cf
    import sbox_cf_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [7:0] data_i,
    input  logic       inv_mode_i,
    output logic [7:0] data_o
);

    localparam int NUM_DIR = 2;   // 0: forward, 1: inverse
    localparam mat_t  IN_MAT  [NUM_DIR] = '{FWD_IN_MAT, INV_IN_MAT};
    localparam byte_t IN_OFS  [NUM_DIR] = '{8'h00, INV_IN_OFS};
    localparam mat_t  OUT_MAT [NUM_DIR] = '{FWD_OUT_MAT, INV_OUT_MAT};
    localparam byte_t OUT_OFS [NUM_DIR] = '{FWD_CONST, 8'h00};

    byte_t      in_cf   [NUM_DIR];
    byte_t      out_std [NUM_DIR];
    byte_t      shared_in, shared_out;
    out_state_t st_d, st_q;

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
        sbox_cf_linmap #(.MAT(IN_MAT[g]), .OFS(IN_OFS[g])) u_in_map (
            .vec_i (data_i),
            .vec_o (in_cf[g])
        );
        sbox_cf_linmap #(.MAT(OUT_MAT[g]), .OFS(OUT_OFS[g])) u_out_map (
            .vec_i (shared_out),
            .vec_o (out_std[g])
        );
    end

    always_comb begin
        shared_in = inv_mode_i ? in_cf[1] : in_cf[0];
    end

    sbox_cf_inverter u_inverter (
        .cf_i (shared_in),
        .cf_o (shared_out)
    );

    always_comb begin
        st_d      = st_q;
        st_d.data = inv_mode_i ? out_std[1] : out_std[0];
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) st_q <= '0;
            else         st_q <= st_d;
        end
        assign data_o = st_q.data;
    end else begin : g_comb
        assign st_q   = '0;
        assign data_o = st_d.data;
    end

endmodule

// File: rtl/sbox_cf_chk.sv
module sbox_cf_chk #(
    parameter bit OUT_REG = 1'b1
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [7:0] data_i,
    input logic       inv_mode_i,
    input logic [7:0] data_o,
    input logic [7:0] shared_in,
    input logic [7:0] shared_out
);

    // R3: the shared inverter keeps zero and only zero at zero
    p_zero_fixed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((shared_in == 8'h00) == (shared_out == 8'h00)));

    if (OUT_REG) begin : g_seq
        // R6: output cleared while reset is low
        p_reset_clear_r6: assert property (@(posedge clk_i)
            !rst_ni |-> data_o == 8'h00);

        // R3: zero through the forward direction
        p_fwd_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!inv_mode_i && data_i == 8'h00) |=> data_o == 8'h63);

        // R3: zero back out through the inverse direction
        p_inv_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (inv_mode_i && data_i == 8'h63) |=> data_o == 8'h00);

        // R1: a fixed forward value, one cycle later
        p_fwd_one_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!inv_mode_i && data_i == 8'h01) |=> data_o == 8'h7C);

        // R2: a fixed inverse value, one cycle later
        p_inv_null_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (inv_mode_i && data_i == 8'h00) |=> data_o == 8'h52);

        // R5: constant inputs over two edges give a constant output
        p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($stable(data_i) && $stable(inv_mode_i) && $past(rst_ni))
            |=> $stable(data_o));
    end

endmodule

bind sbox_cf sbox_cf_chk #(.OUT_REG(OUT_REG)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_i     (data_i),
    .inv_mode_i (inv_mode_i),
    .data_o     (data_o),
    .shared_in  (shared_in),
    .shared_out (shared_out)
);

// File: tb/sbox_cf_tb.sv
module sbox_cf_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;
    localparam int SEED       = 32'h5B0C_A11E;

    logic       clk = 1'b0;
    logic       rst_ni = 1'b1;
    logic [7:0] din = 8'h00;
    logic       mode = 1'b0;
    logic [7:0] dout;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] ref_fwd [256];
    logic [7:0] ref_inv [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    sbox_cf u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_ni),
        .data_i     (din),
        .inv_mode_i (mode),
        .data_o     (dout)
    );

    function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b);
        logic [15:0] prod = '0;
        for (int i = 0; i < 8; i++) if (b[i]) prod = prod ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (prod[i]) prod = prod ^ (16'h011B << (i - 8));
        return prod[7:0];
    endfunction

    function automatic logic [7:0] ref_recip(logic [7:0] a);
        logic [7:0] r = 8'h00;
        for (int c = 1; c < 256; c++) if (ref_mul(a, 8'(c)) == 8'h01) r = 8'(c);
        return r;
    endfunction

    function automatic logic [7:0] ref_affine(logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++)
            r[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8];
        return r ^ 8'h63;
    endfunction

    task automatic check(logic [7:0] act, logic [7:0] exp, string req, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic apply(logic [7:0] x, logic m);
        @(negedge clk);
        din  = x;
        mode = m;
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(SEED));
        for (int x = 0; x < 256; x++) ref_fwd[x] = ref_affine(ref_recip(8'(x)));
        for (int x = 0; x < 256; x++) ref_inv[ref_fwd[x]] = 8'(x);

        // R6: reset state with an input whose substitution is nonzero
        #1 rst_ni = 1'b0;
        din = 8'h00; mode = 1'b0;
        repeat (3) @(negedge clk);
        check(dout, 8'h00, "R6", "reset state");
        rst_ni = 1'b1;

        // directed corners
        apply(8'h00, 1'b0); check(dout, 8'h63, "R3", "forward of zero");
        apply(8'h63, 1'b1); check(dout, 8'h00, "R3", "inverse of 0x63");
        apply(8'h01, 1'b0); check(dout, 8'h7C, "R1", "forward of 0x01");
        apply(8'h53, 1'b0); check(dout, 8'hED, "R1", "forward of 0x53");
        apply(8'h00, 1'b1); check(dout, 8'h52, "R2", "inverse of zero");
        apply(8'hFF, 1'b0); check(dout, ref_fwd[8'hFF], "R1", "forward of 0xFF");

        // R1 / R2: full sweep in both directions
        for (int x = 0; x < 256; x++) begin
            apply(8'(x), 1'b0); check(dout, ref_fwd[x], "R1", "forward sweep");
            apply(8'(x), 1'b1); check(dout, ref_inv[x], "R2", "inverse sweep");
        end

        // R4: round trip through the design in both directions
        for (int i = 0; i < 64; i++) begin
            logic [7:0] x = 8'($urandom());
            logic [7:0] y;
            apply(x, 1'b0); y = dout;
            apply(y, 1'b1); check(dout, x, "R4", "round trip");
        end

        // R5: output holds until the next rising edge
        apply(8'h10, 1'b0);
        @(negedge clk);
        din = 8'h20; mode = 1'b1;
        #1 check(dout, ref_fwd[8'h10], "R5", "held before edge");
        @(posedge clk);
        #1 check(dout, ref_inv[8'h20], "R5", "updated after edge");

        // R7: back-to-back stream with random mode
        begin
            logic [7:0] exp_prev = 8'h00;
            for (int i = 0; i < 300; i++) begin
                logic [7:0] x = 8'($urandom());
                logic       m = 1'($urandom());
                @(negedge clk);
                if (i > 0) check(dout, exp_prev, "R7", "streaming");
                din = x; mode = m;
                exp_prev = m ? ref_inv[x] : ref_fwd[x];
            end
            @(negedge clk);
            check(dout, exp_prev, "R7", "streaming tail");
        end

        // R6: reset in mid-run clears at once and holds
        apply(8'h00, 1'b0);
        check(dout, 8'h63, "R3", "before mid-run reset");
        rst_ni = 1'b0;
        #1 check(dout, 8'h00, "R6", "asynchronous clear");
        @(negedge clk);
        check(dout, 8'h00, "R6", "held in reset");
        rst_ni = 1'b1;
        apply(8'h01, 1'b0); check(dout, 8'h7C, "R1", "after reset release");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule